// File: doc/BRIEF.md
# Cascadable Shift-and-Store Register

This block turns a serial bit stream into a parallel word. Bits enter a 16-bit shift register on falling edges of a shift strobe, and a store strobe copies the shift register into a 16-bit storage register. The storage register drives the parallel output. The top bit of the shift register is the serial output, so several instances can be chained into a longer word. The block can also copy the storage register back into the shift register, so a stored word can be shifted out again.

An active-low chip select and a read/write control pick the operation. With chip select high, both registers hold. With chip select low and read/write low, the block shifts and stores. With read/write high, a falling shift strobe either shifts or copies the storage register back, depending on the store strobe level at that moment. Storing is blocked in that mode.

Both strobes, both controls and the serial input are sampled by one system clock. The block acts only on real strobe transitions found in those samples.

Top module: `shift_store_reg`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the storage register to zero. The parallel output and the serial output then read 0.
- R2: With chip select low and read/write low, a falling shift strobe shifts the register up by one bit whatever the store strobe level. The sampled serial input enters bit 0.
- R3: The serial output always equals bit 15 of the shift register, so the first bit shifted in appears there after 16 shifts.
- R4: With chip select low, read/write high and the store strobe low, a falling shift strobe shifts the register exactly as in R2.
- R5: With chip select low, read/write high and the store strobe high, a falling shift strobe copies the storage register into the shift register and does not shift.
- R6: With chip select low and read/write low, a rising store strobe copies the shift register to the storage register, which drives the parallel output (bit i of the output is storage bit i).
- R7: A rising store strobe leaves the storage register unchanged when chip select is high or read/write is high.
- R8: While chip select is high, a falling shift strobe changes neither register.
- R9: Transitions on chip select or read/write alone, with both strobes steady, never update either register.
- R10: A strobe edge changes the registers at the second system clock edge after the input changes. At the first edge after the change, the registers have not yet changed.
- R11: If a store rising edge and a shift falling edge are seen in the same cycle, the storage register captures the shift register value from before the shift, and the shift still takes place.
- R12: A rising shift strobe or a falling store strobe changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into bit 0 |
| shift_strobe | input | 1 | Shift strobe, acted on at its falling edge |
| store_strobe | input | 1 | Store strobe, acted on at its rising edge; its level also selects load-back |
| csel_n | input | 1 | Chip select, active low |
| rw | input | 1 | Read/write mode control |
| ser_out | output | 1 | Bit 15 of the shift register, for chaining |
| par_out | output | 16 | Storage register contents |

## Verification
A corrupt shift register bit shows on the serial output once it reaches bit 15. It shows on the parallel output at the next store, two system clocks after the store strobe rises. A corrupt storage register shows on the parallel output at once. If the shift register goes wrong after a load-back, the next store exposes it. Because of this, the bench follows every mode case with a store and a parallel-output comparison. The mode sweep covers every combination of chip select, read/write, store level and serial bit.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } sh_op_e;

  // Shift the word up by one place and put the new bit at position 0.
  function automatic logic [15:0] shift_up16(input logic [15:0] w, input logic b);
    return {w[14:0], b};
  endfunction

  // Choose the shift register operation from the sampled controls.
  function automatic sh_op_e pick_op(input logic cs_n, input logic rw_l,
                                     input logic st_lvl, input logic fall);
    if (!fall || cs_n)      return OP_HOLD;
    else if (rw_l && st_lvl) return OP_LOAD;
    else                    return OP_SHIFT;
  endfunction
endpackage

// File: rtl/sss_strobe_edge.sv
module sss_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic cur_q;
  logic prv_q;

  // During reset both samples follow the input, so no false edge appears after release.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= din;
      prv_q <= din;
    end else begin
      cur_q <= din;
      prv_q <= cur_q;
    end
  end

  assign lvl  = cur_q;
  assign rise = cur_q & ~prv_q;
  assign fall = prv_q & ~cur_q;
endmodule

// File: rtl/sss_decode.sv
module sss_decode
  import sss_pkg::*;
(
  input  logic cs_q,
  input  logic rw_q,
  input  logic store_lvl,
  input  logic shift_fall,
  input  logic store_rise,
  output logic do_shift,
  output logic do_load,
  output logic do_store
);
  sh_op_e op;

  always_comb begin
    op       = pick_op(cs_q, rw_q, store_lvl, shift_fall);
    do_shift = (op == OP_SHIFT);
    do_load  = (op == OP_LOAD);
    do_store = store_rise & ~cs_q & ~rw_q;
  end
endmodule

// File: rtl/sss_shift_reg.sv
module sss_shift_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_shift,
  input  logic             do_load,
  input  logic             ser,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (do_load)  q <= load_val;
    else if (do_shift) q <= {q[WIDTH-2:0], ser};
  end
endmodule

// File: rtl/sss_store_reg.sv
module sss_store_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_store,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (do_store) q <= d;
  end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_strobe,
  input  logic             store_strobe,
  input  logic             csel_n,
  input  logic             rw,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_out
);
  localparam int MSB = WIDTH - 1;

  logic cs_q, rw_q, ser_q;
  logic shift_lvl, shift_rise, shift_fall;
  logic store_lvl, store_rise, store_fall;
  logic do_shift, do_load, do_store;
  logic [MSB:0] sh_q, st_q;

  // Sample the controls and the data in the same cycle as the strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      rw_q  <= 1'b0;
      ser_q <= 1'b0;
    end else begin
      cs_q  <= csel_n;
      rw_q  <= rw;
      ser_q <= ser_in;
    end
  end

  sss_strobe_edge u_shift_edge (
    .clk(clk), .rst(rst), .din(shift_strobe),
    .lvl(shift_lvl), .rise(shift_rise), .fall(shift_fall)
  );

  sss_strobe_edge u_store_edge (
    .clk(clk), .rst(rst), .din(store_strobe),
    .lvl(store_lvl), .rise(store_rise), .fall(store_fall)
  );

  sss_decode u_dec (
    .cs_q(cs_q), .rw_q(rw_q), .store_lvl(store_lvl),
    .shift_fall(shift_fall), .store_rise(store_rise),
    .do_shift(do_shift), .do_load(do_load), .do_store(do_store)
  );

  sss_shift_reg #(.WIDTH(WIDTH)) u_sh (
    .clk(clk), .rst(rst), .do_shift(do_shift), .do_load(do_load),
    .ser(ser_q), .load_val(st_q), .q(sh_q)
  );

  sss_store_reg #(.WIDTH(WIDTH)) u_st (
    .clk(clk), .rst(rst), .do_store(do_store), .d(sh_q), .q(st_q)
  );

  assign ser_out = sh_q[MSB];
  assign par_out = st_q;
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_q,
  input logic             rw_q,
  input logic             ser_q,
  input logic             store_lvl,
  input logic             shift_fall,
  input logic             store_rise,
  input logic             shift_rise,
  input logic             store_fall,
  input logic [WIDTH-1:0] sh_q,
  input logic [WIDTH-1:0] st_q
);
  assert_shift_rw_low_R2: assert property (@(posedge clk) disable iff (rst)
    (shift_fall && !cs_q && !rw_q) |=>
      (sh_q[0] == $past(ser_q)) && (sh_q[WIDTH-1:1] == $past(sh_q[WIDTH-2:0])));

  assert_shift_rw_high_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_fall && !cs_q && rw_q && !store_lvl) |=>
      (sh_q[0] == $past(ser_q)) && (sh_q[WIDTH-1:1] == $past(sh_q[WIDTH-2:0])));

  assert_load_back_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_fall && !cs_q && rw_q && store_lvl) |=> (sh_q == $past(st_q)));

  assert_store_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (store_rise && !cs_q && !rw_q) |=> (st_q == $past(sh_q)));

  assert_store_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_q || rw_q) |=> $stable(st_q));

  assert_cs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> ($stable(sh_q) && $stable(st_q)));

  assert_no_edge_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!shift_fall && !store_rise) |=> ($stable(sh_q) && $stable(st_q)));

  assert_wrong_edges_R12: assert property (@(posedge clk) disable iff (rst)
    ((shift_rise || store_fall) && !shift_fall && !store_rise) |=>
      ($stable(sh_q) && $stable(st_q)));
endmodule

bind shift_store_reg sss_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .rw_q(rw_q), .ser_q(ser_q),
  .store_lvl(store_lvl), .shift_fall(shift_fall), .store_rise(store_rise),
  .shift_rise(shift_rise), .store_fall(store_fall), .sh_q(sh_q), .st_q(st_q)
);

// File: tb/tb_shift_store_reg.sv
module tb_shift_store_reg;
  logic clk = 1'b0;
  logic rst, ser_in, shift_strobe, store_strobe, csel_n, rw;
  logic ser_out;
  logic [15:0] par_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] m_sh, m_st;

  always #10 clk = ~clk;

  shift_store_reg dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_strobe(shift_strobe),
    .store_strobe(store_strobe), .csel_n(csel_n), .rw(rw),
    .ser_out(ser_out), .par_out(par_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Store: chip select low, read/write low, rising store strobe, then back low.
  task automatic do_store(input string req);
    @(negedge clk);
    csel_n = 1'b0; rw = 1'b0; store_strobe = 1'b1;
    settle();
    m_st = m_sh;
    chk(req, par_out, m_st);
    store_strobe = 1'b0;
    settle();
    chk("R12", par_out, m_st);
  endtask

  // Falling shift strobe with the current controls, then back high.
  task automatic shift_edge(input logic b);
    @(negedge clk);
    ser_in = b; shift_strobe = 1'b0;
    settle();
    if (!csel_n) begin
      if (rw && store_strobe) m_sh = m_st;
      else m_sh = {m_sh[14:0], b};
    end
    shift_strobe = 1'b1;
    settle();
  endtask

  initial begin
    logic [15:0] pat, old_sh;
    rst = 1'b1; ser_in = 1'b0; shift_strobe = 1'b1; store_strobe = 1'b0;
    csel_n = 1'b0; rw = 1'b0;
    m_sh = '0; m_st = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R1 par", par_out, 16'h0);
    chk("R1 ser", {15'd0, ser_out}, 16'h0);
    do_store("R1 shift reg");

    // Shift several words in, most significant bit first, then store them.
    foreach (pat_list[i]) begin
      pat = pat_list[i];
      csel_n = 1'b0; rw = (i % 2 == 1);
      for (int k = 15; k >= 0; k--) begin
        shift_edge(pat[k]);
        chk(rw ? "R4 ser" : "R2 ser", {15'd0, ser_out}, {15'd0, m_sh[15]});
      end
      chk("R3 first bit", {15'd0, ser_out}, {15'd0, pat[15]});
      do_store("R6 word");
      chk("R6 word", par_out, pat);
    end

    // Latency: registers act at the second clock edge after the change.
    m_sh = 16'h0001;
    for (int k = 15; k >= 0; k--) shift_edge(m_sh[k]);
    @(negedge clk);
    store_strobe = 1'b1;
    @(negedge clk);
    chk("R10 not yet", par_out, m_st);
    @(negedge clk);
    chk("R10 now", par_out, m_sh);
    m_st = m_sh;
    store_strobe = 1'b0;
    settle();

    // Sweep every control, store level and data bit combination for a shift edge.
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      csel_n = c[3]; rw = c[2];
      settle();
      store_strobe = c[1];
      settle();
      if (c[1] && !c[3] && !c[2]) m_st = m_sh;
      shift_edge(c[0]);
      chk(c[3] ? "R8 ser" : (c[2] && c[1]) ? "R5 ser" : "R2 ser",
          {15'd0, ser_out}, {15'd0, m_sh[15]});
      chk(c[3] ? "R8 par" : "R7 par", par_out, m_st);
      store_strobe = 1'b0;
      settle();
      do_store(c[3] ? "R8 shift reg" : (c[2] && c[1]) ? "R5 shift reg" :
               c[2] ? "R4 shift reg" : "R2 shift reg");
      // Set up a different shift value for the next case.
      csel_n = 1'b0; rw = 1'b0;
      shift_edge(~c[0]);
      shift_edge(c[1]);
    end

    // Stores blocked by read/write high or chip select high.
    for (int c = 1; c < 4; c++) begin
      shift_edge(1'b1);
      @(negedge clk);
      csel_n = c[1]; rw = c[0];
      settle();
      store_strobe = 1'b1;
      settle();
      chk("R7 blocked", par_out, m_st);
      store_strobe = 1'b0;
      settle();
      csel_n = 1'b0; rw = 1'b0;
      settle();
    end

    // Control toggles with steady strobes.
    shift_edge(1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      csel_n = k[0]; rw = k[1];
      @(negedge clk);
    end
    csel_n = 1'b0; rw = 1'b0;
    settle();
    chk("R9 par", par_out, m_st);
    chk("R9 ser", {15'd0, ser_out}, {15'd0, m_sh[15]});
    do_store("R9 shift reg");

    // Wrong-direction strobe edges: drop shift strobe while chip select high, then raise it with chip select low.
    @(negedge clk);
    csel_n = 1'b1; shift_strobe = 1'b0;
    settle();
    csel_n = 1'b0;
    settle();
    shift_strobe = 1'b1;
    settle();
    chk("R12 rise", par_out, m_st);
    do_store("R12 shift reg");

    // Simultaneous store rise and shift fall.
    m_sh = 16'h8421;
    for (int k = 15; k >= 0; k--) shift_edge(m_sh[k]);
    old_sh = m_sh;
    @(negedge clk);
    csel_n = 1'b0; rw = 1'b0;
    ser_in = 1'b1; shift_strobe = 1'b0; store_strobe = 1'b1;
    settle();
    m_st = old_sh;
    m_sh = {old_sh[14:0], 1'b1};
    chk("R11 stored", par_out, old_sh);
    chk("R11 ser", {15'd0, ser_out}, {15'd0, m_sh[15]});
    shift_strobe = 1'b1; store_strobe = 1'b0;
    settle();
    do_store("R11 shifted");

    // Reset again from a non-zero state.
    @(negedge clk);
    rst = 1'b1;
    settle();
    rst = 1'b0;
    settle();
    m_sh = '0; m_st = '0;
    chk("R1 again", par_out, 16'h0);
    do_store("R1 again shift reg");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [15:0] pat_list [4] = '{16'hA5C3, 16'h7E01, 16'hFFFF, 16'h1248};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule